// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

This peripheral turns a slow base strobe (nominally 60 Hz) into a programmable tick rate for a small 16-bit processor. A divider counts base strobes. When the count reaches a programmed divisor, the divider restarts and a 16-bit elapsed-tick counter advances by one. If a nonzero message word has been programmed, the tick also raises a one-cycle interrupt request that carries that word.

The processor controls the block with a one-cycle command strobe. Each command has a 16-bit command code and a 16-bit argument. Only the read-ticks command produces a result, and that result is held in a registered output. The block also presents fixed identification values (device ID, vendor code, version) for device enumeration.

Top module: `periodic_tick_timer`

## Requirements
- R1: After synchronous reset, `result` is 0, `irq_valid` is 0, and the first read-ticks command returns 0.
- R2: Code 0 (set rate) loads `cmd_arg` as the divisor D. With D nonzero, the tick count advances once for every D base strobes.
- R3: Code 1 (read ticks) loads the current tick count into `result` on the same clock edge that clears the count. A second read with no strobes in between returns 0.
- R4: While the divisor is 0, base strobes change neither the divider nor the tick count, and no interrupt is raised.
- R5: When a tick occurs and the stored message is nonzero, `irq_valid` is high for exactly the cycle after that strobe edge, and `irq_msg` equals the stored message.
- R6: Code 2 (set message) stores `cmd_arg`. A stored value of 0 suppresses interrupts, but ticks are still counted.
- R7: A command code other than 0, 1 or 2 leaves the divisor, message, tick count and `result` unchanged.
- R8: If a read-ticks command and a tick fall on the same clock edge, the returned value includes that tick and the counter is left at 0.
- R9: The 16-bit tick count wraps from 0xFFFF to 0x0000 with no other effect.
- R10: `dev_id` is 0x12d0b402, `dev_vendor` is 0x1c6c8b36 and `dev_version` is 2.
- R11: `result` changes only on a read-ticks command. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_pulse | input | 1 | One-cycle base-rate strobe |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 16 | Command code (0 set rate, 1 read ticks, 2 set message) |
| cmd_arg | input | 16 | Command argument |
| result | output | 16 | Registered tick count returned by read ticks |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_msg | output | 16 | Message word carried with the interrupt request |
| dev_id | output | 32 | Hardware identification |
| dev_vendor | output | 32 | Vendor code |
| dev_version | output | 16 | Version number |

## Verification
Every result appears one clock edge after the stimulus that causes it. A command sampled at edge N is visible on `result` after edge N. A strobe that completes a divisor period at edge N raises `irq_valid` during the cycle after edge N. The bench drives inputs on falling edges and reads outputs on the next falling edge, so each sample is taken half a cycle after the edge that produced it. Interrupts are counted by a falling-edge monitor, so each one-cycle pulse is seen exactly once.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [WORD_W-1:0] {
    CMD_SET_RATE   = 16'd0,
    CMD_READ_TICKS = 16'd1,
    CMD_SET_MSG    = 16'd2
  } cmd_e;

  typedef struct packed {
    logic set_rate;
    logic read_ticks;
    logic set_msg;
  } cmd_dec_t;
endpackage

// File: rtl/ptt_cmd_decode.sv
module ptt_cmd_decode
  import ptt_pkg::*;
(
  input  logic     valid,
  input  word_t    code,
  output cmd_dec_t dec
);
  always_comb begin
    dec = '0;
    if (valid) begin
      unique case (code)
        CMD_SET_RATE:   dec.set_rate   = 1'b1;
        CMD_READ_TICKS: dec.read_ticks = 1'b1;
        CMD_SET_MSG:    dec.set_msg    = 1'b1;
        default:        dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptt_divider.sv
module ptt_divider #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         base_pulse,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] divisor_q,
  output logic         tick_evt
);
  logic [W-1:0] count_q;
  logic [W:0]   count_nx;
  logic         running;

  assign running  = (divisor_q != '0);
  assign count_nx = {1'b0, count_q} + 1'b1;
  assign tick_evt = base_pulse && running && (count_nx >= {1'b0, divisor_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      divisor_q <= '0;
      count_q   <= '0;
    end else begin
      if (load) divisor_q <= load_val;
      if (base_pulse && running) begin
        if (tick_evt) count_q <= '0;
        else          count_q <= count_nx[W-1:0];
      end
    end
  end
endmodule

// File: rtl/ptt_tick_counter.sv
module ptt_tick_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_evt,
  input  logic         read_req,
  output logic [W-1:0] ticks_q,
  output logic [W-1:0] result_q
);
  logic [W-1:0] ticks_nx;

  assign ticks_nx = ticks_q + {{(W-1){1'b0}}, tick_evt};

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks_q  <= '0;
      result_q <= '0;
    end else if (read_req) begin
      result_q <= ticks_nx;
      ticks_q  <= '0;
    end else begin
      ticks_q  <= ticks_nx;
    end
  end
endmodule

// File: rtl/ptt_irq_gen.sv
module ptt_irq_gen #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_evt,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         irq_valid,
  output logic [W-1:0] irq_msg
);
  logic [W-1:0] msg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_q     <= '0;
      irq_valid <= 1'b0;
      irq_msg   <= '0;
    end else begin
      if (load) msg_q <= load_val;
      irq_valid <= tick_evt && (msg_q != '0);
      if (tick_evt) irq_msg <= msg_q;
    end
  end
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import ptt_pkg::*;
#(
  parameter logic [31:0] HW_ID      = 32'h12d0b402,
  parameter logic [31:0] HW_VENDOR  = 32'h1c6c8b36,
  parameter logic [15:0] HW_VERSION = 16'd2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        base_pulse,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_code,
  input  logic [15:0] cmd_arg,
  output logic [15:0] result,
  output logic        irq_valid,
  output logic [15:0] irq_msg,
  output logic [31:0] dev_id,
  output logic [31:0] dev_vendor,
  output logic [15:0] dev_version
);
  cmd_dec_t dec;
  word_t    divisor_q;
  word_t    ticks_q;
  logic     tick_evt;

  assign dev_id      = HW_ID;
  assign dev_vendor  = HW_VENDOR;
  assign dev_version = HW_VERSION;

  ptt_cmd_decode u_dec (
    .valid (cmd_valid),
    .code  (cmd_code),
    .dec   (dec)
  );

  ptt_divider #(.W(WORD_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .base_pulse (base_pulse),
    .load       (dec.set_rate),
    .load_val   (cmd_arg),
    .divisor_q  (divisor_q),
    .tick_evt   (tick_evt)
  );

  ptt_tick_counter #(.W(WORD_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick_evt (tick_evt),
    .read_req (dec.read_ticks),
    .ticks_q  (ticks_q),
    .result_q (result)
  );

  ptt_irq_gen #(.W(WORD_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .tick_evt  (tick_evt),
    .load      (dec.set_msg),
    .load_val  (cmd_arg),
    .irq_valid (irq_valid),
    .irq_msg   (irq_msg)
  );
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker (
  input logic        clk,
  input logic        rst,
  input logic        base_pulse,
  input logic        cmd_valid,
  input logic [15:0] cmd_code,
  input logic [15:0] result,
  input logic        irq_valid,
  input logic [15:0] irq_msg,
  input logic [15:0] divisor_q,
  input logic [15:0] ticks_q
);
  logic rd;
  assign rd = cmd_valid && (cmd_code == 16'd1);

  p_read_clear_r3: assert property (@(posedge clk) disable iff (rst)
    rd |=> (ticks_q == 16'd0));

  p_halt_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (divisor_q == 16'd0 && !rd) |=> $stable(ticks_q));

  p_no_irq_halted_r4: assert property (@(posedge clk) disable iff (rst)
    (divisor_q == 16'd0) |=> !irq_valid);

  p_irq_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> $past(base_pulse));

  p_irq_msg_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_msg != 16'd0));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(result));
endmodule

bind periodic_tick_timer ptt_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .base_pulse (base_pulse),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .result     (result),
  .irq_valid  (irq_valid),
  .irq_msg    (irq_msg),
  .divisor_q  (divisor_q),
  .ticks_q    (ticks_q)
);

// File: tb/periodic_tick_timer_tb.sv
module periodic_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_pulse = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_code = '0;
  logic [15:0] cmd_arg = '0;
  logic [15:0] result;
  logic        irq_valid;
  logic [15:0] irq_msg;
  logic [31:0] dev_id;
  logic [31:0] dev_vendor;
  logic [15:0] dev_version;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  logic [15:0] last_msg = '0;

  always #4 clk = ~clk;

  periodic_tick_timer u_dut (
    .clk(clk), .rst(rst), .base_pulse(base_pulse), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_arg(cmd_arg), .result(result),
    .irq_valid(irq_valid), .irq_msg(irq_msg), .dev_id(dev_id),
    .dev_vendor(dev_vendor), .dev_version(dev_version)
  );

  always @(negedge clk) begin
    if (!rst && irq_valid) begin
      irq_cnt  <= irq_cnt + 1;
      last_msg <= irq_msg;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [15:0] code, input logic [15:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0; cmd_arg = '0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      base_pulse = 1'b1;
      @(negedge clk);
      base_pulse = 1'b0;
    end
  endtask

  task automatic read_expect(input string req, input logic [15:0] exp);
    do_cmd(16'd1, 16'h0);
    check(req, {16'h0, result}, {16'h0, exp});
  endtask

  task automatic t_reset;
    check("R1 result", {16'h0, result}, 32'h0);
    check("R1 irq", {31'h0, irq_valid}, 32'h0);
    read_expect("R1 first read", 16'd0);
    check("R10 id", dev_id, 32'h12d0b402);
    check("R10 vendor", dev_vendor, 32'h1c6c8b36);
    check("R10 version", {16'h0, dev_version}, 32'd2);
  endtask

  task automatic t_divide;
    do_cmd(16'd0, 16'd3);
    strobes(9);
    read_expect("R2 div3 nine strobes", 16'd3);
    read_expect("R3 reread cleared", 16'd0);
  endtask

  task automatic t_irq;
    int base;
    base = irq_cnt;
    do_cmd(16'd2, 16'hABCD);
    do_cmd(16'd0, 16'd2);
    strobes(4);
    @(negedge clk);
    check("R5 irq count", irq_cnt - base, 32'd2);
    check("R5 irq msg", {16'h0, last_msg}, 32'h0000ABCD);
    read_expect("R2 div2 four strobes", 16'd2);
  endtask

  task automatic t_nomsg;
    int base;
    base = irq_cnt;
    do_cmd(16'd2, 16'd0);
    strobes(4);
    @(negedge clk);
    check("R6 no irq", irq_cnt - base, 32'd0);
    read_expect("R6 still counts", 16'd2);
  endtask

  task automatic t_zero;
    int base;
    do_cmd(16'd2, 16'h0055);
    base = irq_cnt;
    do_cmd(16'd0, 16'd0);
    strobes(10);
    @(negedge clk);
    check("R4 no irq halted", irq_cnt - base, 32'd0);
    read_expect("R4 halted count", 16'd0);
  endtask

  task automatic t_ignore;
    do_cmd(16'd0, 16'd1);
    strobes(3);
    read_expect("R2 div1", 16'd3);
    strobes(2);
    do_cmd(16'd5, 16'd0);
    do_cmd(16'h0010, 16'd0);
    do_cmd(16'hFFFF, 16'd7);
    check("R11 result held", {16'h0, result}, 32'd3);
    strobes(2);
    read_expect("R7 unknown ignored", 16'd4);
  endtask

  task automatic t_coincide;
    do_cmd(16'd0, 16'd1);
    strobes(2);
    @(negedge clk);
    base_pulse = 1'b1; cmd_valid = 1'b1; cmd_code = 16'd1;
    @(negedge clk);
    base_pulse = 1'b0; cmd_valid = 1'b0; cmd_code = '0;
    check("R8 coincident read", {16'h0, result}, 32'd3);
    read_expect("R8 left zero", 16'd0);
  endtask

  task automatic t_wrap;
    do_cmd(16'd2, 16'd0);
    do_cmd(16'd0, 16'd1);
    @(negedge clk);
    base_pulse = 1'b1;
    repeat (65537) @(negedge clk);
    base_pulse = 1'b0;
    read_expect("R9 wrap", 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_divide;
    t_irq;
    t_nomsg;
    t_zero;
    t_ignore;
    t_coincide;
    t_wrap;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule